// File: doc/BRIEF.md
# Receive Character Queue with Error Tags

This block buffers characters coming out of a serial receiver until the processor takes them. Every stored character travels with three status tags (parity error, framing error and break), so the status the processor sees always belongs to the character it will read next. In buffered mode the queue holds sixteen characters. In holding mode it keeps a single character.

A 2-bit code picks the fill level at which the block asks for service. When that level is reached, an interrupt line and a DMA request rise and a request-to-send output drops, which tells the far end to pause. A character that arrives when there is no room is thrown away and a sticky overrun flag is raised. A synchronous clear empties the queue. Switching between buffered and holding mode also empties it.

Top module: `rxq_fifo`

## Requirements
- R1: With `fifo_en`=1 the queue accepts 16 characters, and `fill_cnt` reaches 16. Characters leave in arrival order.
- R2: Each entry stores the data byte together with its parity-error, framing-error and break tags. The `head_*` outputs show the oldest entry while `data_rdy` is 1.
- R3: `data_rdy` is 1 exactly when `fill_cnt` is non-zero. It rises in the cycle after the push edge.
- R4: In buffered mode `trig_sel` sets the threshold: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14. `irq` and `dma_req` are 1 exactly when `fill_cnt` is at or above the threshold.
- R5: `rts` is 1 while `fill_cnt` is below the threshold. It is 0 once `fill_cnt` reaches the threshold.
- R6: With `fifo_en`=0 the block holds one character, and the threshold is fixed at 1.
- R7: A push into a full queue with no pop in the same cycle is discarded. The stored characters and `fill_cnt` are left unchanged, and `overrun` goes to 1.
- R8: `overrun` stays at 1 until a `status_rd` pulse clears it. If a discard and a `status_rd` fall in the same cycle, `overrun` ends at 1.
- R9: `clr` empties the queue in one cycle and leaves `overrun` untouched. A push or pop in the same cycle is ignored.
- R10: Any change of `fifo_en` empties the queue at the next clock edge.
- R11: A pop while the queue is empty has no effect: `fill_cnt` stays 0, and later pushes and pops keep their order.
- R12: A push and a pop in the same cycle on a full queue both take effect. `fill_cnt` stays at 16 and `overrun` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 = sixteen-entry buffered mode, 0 = single holding mode |
| trig_sel | input | 2 | Threshold code |
| clr | input | 1 | Synchronous empty request |
| push | input | 1 | Write strobe from the receive shifter |
| push_data | input | 8 | Received character |
| push_perr | input | 1 | Parity-error tag of the character |
| push_ferr | input | 1 | Framing-error tag of the character |
| push_brk | input | 1 | Break tag of the character |
| pop | input | 1 | Processor read strobe |
| status_rd | input | 1 | Status read pulse; clears overrun |
| head_data | output | 8 | Oldest stored character |
| head_perr | output | 1 | Parity-error tag of the oldest character |
| head_ferr | output | 1 | Framing-error tag of the oldest character |
| head_brk | output | 1 | Break tag of the oldest character |
| data_rdy | output | 1 | At least one character stored |
| fill_cnt | output | 5 | Number of stored characters |
| irq | output | 1 | Threshold reached, interrupt request |
| dma_req | output | 1 | Threshold reached, DMA request |
| rts | output | 1 | 1 while more characters may be sent |
| overrun | output | 1 | Sticky flag: a character was discarded |

## Verification
Some properties are checked on every cycle by assertions:
- the fill bound in each mode;
- the empty result of a clear;
- the frozen count after a discard;
- that an empty pop does nothing;
- the set, hold and clear rules of the overrun flag.

Other behaviour only the directed scenarios can show: the arrival order of data, the tags paired with each character, the exact count at which each of the four threshold codes switches the request and flow-control outputs, and the flush on a mode change.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_DW = 8;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [RXQ_DW-1:0] data;
  } rxq_ent_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     flush,
  input  logic     wr_en,
  input  logic     rd_en,
  input  rxq_ent_t wr_ent,
  output rxq_ent_t head
);
  rxq_ent_t mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_ent;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign head = mem[rd_ptr];

  // R9: an emptying request realigns both pointers
  assert_flush_aligns_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (rd_ptr == wr_ptr));
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int DEPTH = 16,
  parameter int TRIG0 = 1,
  parameter int TRIG1 = 4,
  parameter int TRIG2 = 8,
  parameter int TRIG3 = 14,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic [1:0]    trig_sel,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  output logic          wr_en,
  output logic          rd_en,
  output logic          drop,
  output logic          flush,
  output logic [CW-1:0] count_q,
  output logic          rdy_q,
  output logic          thr_q
);
  localparam logic [CW-1:0] FULL_BUF  = CW'(DEPTH);
  localparam logic [CW-1:0] FULL_HOLD = CW'(1);
  localparam logic [CW-1:0] LVL0 = CW'(TRIG0);
  localparam logic [CW-1:0] LVL1 = CW'(TRIG1);
  localparam logic [CW-1:0] LVL2 = CW'(TRIG2);
  localparam logic [CW-1:0] LVL3 = CW'(TRIG3);

  logic          mode_q;
  logic [CW-1:0] cap, count_d, lvl;

  always_comb begin
    cap     = mode_q ? FULL_BUF : FULL_HOLD;
    flush   = clr | (fifo_en != mode_q);
    rd_en   = !flush && pop && (count_q != '0);
    wr_en   = !flush && push && ((count_q < cap) || rd_en);
    drop    = !flush && push && !wr_en;
    if (flush) count_d = '0;
    else       count_d = count_q + CW'(wr_en) - CW'(rd_en);
    if (!fifo_en) lvl = FULL_HOLD;
    else begin
      case (trig_sel)
        2'b00:   lvl = LVL0;
        2'b01:   lvl = LVL1;
        2'b10:   lvl = LVL2;
        default: lvl = LVL3;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= fifo_en;
      count_q <= '0;
      rdy_q   <= 1'b0;
      thr_q   <= 1'b0;
    end else begin
      mode_q  <= fifo_en;
      count_q <= count_d;
      rdy_q   <= (count_d != '0);
      thr_q   <= (count_d >= lvl);
    end
  end

  // R1: fill never exceeds the buffer depth
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
    count_q <= FULL_BUF);
  // R6: holding mode never keeps more than one character
  assert_single_cap_R6: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> (count_q <= FULL_HOLD));
  // R7: a discarded push leaves the fill unchanged
  assert_drop_holds_R7: assert property (@(posedge clk) disable iff (rst)
    drop |=> (count_q == $past(count_q)));
  // R9: clear empties the queue
  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count_q == '0 && !rdy_q));
  // R11: popping an empty queue leaves it empty
  assert_empty_pop_R11: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && count_q == '0) |=> (count_q == '0));
endmodule

// File: rtl/rxq_ovr.sv
module rxq_ovr (
  input  logic clk,
  input  logic rst,
  input  logic drop,
  input  logic status_rd,
  output logic ovr_q
);
  always_ff @(posedge clk) begin
    if (rst)            ovr_q <= 1'b0;
    else if (drop)      ovr_q <= 1'b1;
    else if (status_rd) ovr_q <= 1'b0;
  end

  // R7: a discard raises the flag
  assert_ovr_set_R7: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovr_q);
  // R8: a status read without a discard clears the flag
  assert_ovr_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !drop) |=> !ovr_q);
  // R8: with neither event the flag is sticky
  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (!drop && !status_rd) |=> (ovr_q == $past(ovr_q)));
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TRIG0 = 1,
  parameter int TRIG1 = 4,
  parameter int TRIG2 = 8,
  parameter int TRIG3 = 14,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en,
  input  logic [1:0]        trig_sel,
  input  logic              clr,
  input  logic              push,
  input  logic [RXQ_DW-1:0] push_data,
  input  logic              push_perr,
  input  logic              push_ferr,
  input  logic              push_brk,
  input  logic              pop,
  input  logic              status_rd,
  output logic [RXQ_DW-1:0] head_data,
  output logic              head_perr,
  output logic              head_ferr,
  output logic              head_brk,
  output logic              data_rdy,
  output logic [CW-1:0]     fill_cnt,
  output logic              irq,
  output logic              dma_req,
  output logic              rts,
  output logic              overrun
);
  logic     wr_en, rd_en, drop, flush, thr_q;
  rxq_ent_t wr_ent, head;

  assign wr_ent = '{brk: push_brk, ferr: push_ferr, perr: push_perr, data: push_data};

  rxq_level #(
    .DEPTH(DEPTH), .TRIG0(TRIG0), .TRIG1(TRIG1), .TRIG2(TRIG2), .TRIG3(TRIG3)
  ) u_level (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .trig_sel(trig_sel), .clr(clr),
    .push(push), .pop(pop), .wr_en(wr_en), .rd_en(rd_en), .drop(drop),
    .flush(flush), .count_q(fill_cnt), .rdy_q(data_rdy), .thr_q(thr_q)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .flush(flush), .wr_en(wr_en), .rd_en(rd_en),
    .wr_ent(wr_ent), .head(head)
  );

  rxq_ovr u_ovr (
    .clk(clk), .rst(rst), .drop(drop), .status_rd(status_rd), .ovr_q(overrun)
  );

  assign head_data = head.data;
  assign head_perr = head.perr;
  assign head_ferr = head.ferr;
  assign head_brk  = head.brk;
  assign irq       = thr_q;
  assign dma_req   = thr_q;
  assign rts       = ~thr_q;

  // R3: the ready flag and the fill count agree
  assert_rdy_count_R3: assert property (@(posedge clk) disable iff (rst)
    data_rdy == (fill_cnt != '0));
endmodule

// File: tb/rxq_fifo_bench.sv
module rxq_fifo_bench;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_en = 1'b1;
  logic [1:0] trig_sel = 2'b11;
  logic       clr = 1'b0, push = 1'b0, pop = 1'b0, status_rd = 1'b0;
  logic [7:0] push_data = '0;
  logic       push_perr = 1'b0, push_ferr = 1'b0, push_brk = 1'b0;
  logic [7:0] head_data;
  logic       head_perr, head_ferr, head_brk, data_rdy, irq, dma_req, rts, overrun;
  logic [4:0] fill_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  rxq_fifo u_rxq_fifo (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .trig_sel(trig_sel), .clr(clr),
    .push(push), .push_data(push_data), .push_perr(push_perr),
    .push_ferr(push_ferr), .push_brk(push_brk), .pop(pop), .status_rd(status_rd),
    .head_data(head_data), .head_perr(head_perr), .head_ferr(head_ferr),
    .head_brk(head_brk), .data_rdy(data_rdy), .fill_cnt(fill_cnt), .irq(irq),
    .dma_req(dma_req), .rts(rts), .overrun(overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic push_one(input logic [7:0] d, input logic [2:0] tags);
    push = 1'b1; push_data = d;
    push_perr = tags[0]; push_ferr = tags[1]; push_brk = tags[2];
    step();
    push = 1'b0;
  endtask

  task automatic pop_one();
    pop = 1'b1; step(); pop = 1'b0;
  endtask

  task automatic do_clr();
    clr = 1'b1; step(); clr = 1'b0;
  endtask

  task automatic read_status();
    status_rd = 1'b1; step(); status_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R3 reset data_rdy", data_rdy, 0);
    chk("R1 reset fill_cnt", fill_cnt, 0);
    chk("R5 reset rts", rts, 1);
    chk("R4 reset irq", irq, 0);
    chk("R8 reset overrun", overrun, 0);
  endtask

  task automatic t_order_tags();
    fifo_en = 1'b1; trig_sel = 2'b11;
    push_one(8'h03, 3'b101);
    chk("R3 data_rdy after push", data_rdy, 1);
    for (int i = 1; i < 16; i++) push_one(8'(i * 17 + 3), 3'(i));
    chk("R1 fill reaches 16", fill_cnt, 16);
    for (int i = 0; i < 16; i++) begin
      chk("R1 order data", head_data, (i * 17 + 3) & 8'hff);
      chk("R2 perr tag", head_perr, (i == 0) ? 1 : (i & 1));
      chk("R2 ferr tag", head_ferr, (i == 0) ? 0 : ((i >> 1) & 1));
      chk("R2 brk tag", head_brk, (i == 0) ? 1 : ((i >> 2) & 1));
      pop_one();
    end
    chk("R3 data_rdy empty", data_rdy, 0);
  endtask

  task automatic t_thresholds();
    int lvl [4] = '{1, 4, 8, 14};
    fifo_en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      do_clr();
      for (int k = 0; k < lvl[s] - 1; k++) push_one(8'(k), 3'b000);
      chk("R4 irq below threshold", irq, 0);
      chk("R5 rts below threshold", rts, 1);
      push_one(8'hA5, 3'b000);
      chk("R4 irq at threshold", irq, 1);
      chk("R4 dma at threshold", dma_req, 1);
      chk("R5 rts at threshold", rts, 0);
      pop_one();
      chk("R4 irq after pop", irq, 0);
      chk("R5 rts after pop", rts, 1);
    end
    do_clr();
  endtask

  task automatic t_overrun();
    fifo_en = 1'b1; trig_sel = 2'b11;
    for (int i = 0; i < 16; i++) push_one(8'(8'h40 + i), 3'b000);
    push_one(8'hEE, 3'b111);
    chk("R7 fill unchanged on discard", fill_cnt, 16);
    chk("R7 overrun set", overrun, 1);
    for (int i = 0; i < 16; i++) begin
      chk("R7 stored data intact", head_data, 8'h40 + i);
      pop_one();
    end
    chk("R8 overrun sticky", overrun, 1);
    read_status();
    chk("R8 overrun cleared", overrun, 0);
    for (int i = 0; i < 16; i++) push_one(8'(i), 3'b000);
    push = 1'b1; push_data = 8'hEE; status_rd = 1'b1;
    step();
    push = 1'b0; status_rd = 1'b0;
    chk("R8 discard wins over status read", overrun, 1);
    read_status();
    push = 1'b1; push_data = 8'h77; pop = 1'b1;
    step();
    push = 1'b0; pop = 1'b0;
    chk("R12 fill stays full", fill_cnt, 16);
    chk("R12 no overrun", overrun, 0);
    chk("R12 head advanced", head_data, 1);
    do_clr();
  endtask

  task automatic t_single();
    fifo_en = 1'b0; trig_sel = 2'b11;
    step();
    push_one(8'h5A, 3'b010);
    chk("R6 holds one", fill_cnt, 1);
    chk("R6 threshold one irq", irq, 1);
    chk("R6 threshold one rts", rts, 0);
    push_one(8'hC3, 3'b000);
    chk("R6 second discarded", head_data, 8'h5A);
    chk("R6 ferr of held char", head_ferr, 1);
    chk("R7 overrun in holding mode", overrun, 1);
    pop_one();
    chk("R6 empty after pop", fill_cnt, 0);
    read_status();
    fifo_en = 1'b1;
    step();
  endtask

  task automatic t_clear();
    fifo_en = 1'b1;
    for (int i = 0; i < 16; i++) push_one(8'(i), 3'b000);
    push_one(8'hEE, 3'b000);
    clr = 1'b1; push = 1'b1; push_data = 8'h11;
    step();
    clr = 1'b0; push = 1'b0;
    chk("R9 clear empties", fill_cnt, 0);
    chk("R9 clear data_rdy", data_rdy, 0);
    chk("R9 overrun kept", overrun, 1);
    read_status();
  endtask

  task automatic t_mode_flush();
    fifo_en = 1'b1;
    for (int i = 0; i < 3; i++) push_one(8'(i), 3'b000);
    fifo_en = 1'b0; step();
    chk("R10 flush to holding", fill_cnt, 0);
    push_one(8'h22, 3'b000);
    fifo_en = 1'b1; step();
    chk("R10 flush to buffered", fill_cnt, 0);
    chk("R10 data_rdy after flush", data_rdy, 0);
  endtask

  task automatic t_empty_pop();
    fifo_en = 1'b1;
    pop_one(); pop_one();
    chk("R11 empty pop fill", fill_cnt, 0);
    chk("R11 empty pop ready", data_rdy, 0);
    push_one(8'h9C, 3'b000);
    push_one(8'h9D, 3'b000);
    chk("R11 order kept head", head_data, 8'h9C);
    pop_one();
    chk("R11 order kept next", head_data, 8'h9D);
    pop_one();
  endtask

  initial begin
    repeat (4) step();
    rst = 1'b0;
    step();
    t_reset();
    t_order_tags();
    t_thresholds();
    t_overrun();
    t_single();
    t_clear();
    t_mode_flush();
    t_empty_pop();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule